// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit core and a word-wide data memory that has one write enable per byte. For every access the core presents, it forms the effective address, checks alignment, and presents a word address to memory. An access can be a word, a halfword or a byte. The effective address is a base register plus either a second register or a sign-extended immediate.

For stores, the unit copies the low bits of the source operand into every lane they could occupy. It then enables only the lanes the access addresses. Lanes are big-endian: byte offset 0 is bits 31:24 of the memory word and offset 3 is bits 7:0.

For loads, memory returns the word one cycle after the request. The unit picks the addressed lane or lanes from it and sign-extends the result to 32 bits. A misaligned access raises a flag and never reaches memory. The unit accepts one access per cycle.

Top module: `lsu_align`

## Requirements
- R1: The effective address is `base + index` when `use_imm` is 0, and `base + sext(imm)` when `use_imm` is 1. `mem_addr` is that address with bits 1:0 forced to zero.
- R2: An aligned word store (size 2'b10 or 2'b11) drives `mem_be` = 4'b1111 and `mem_wdata` = `st_data`.
- R3: A halfword store (size 2'b01) at offset 0 drives `mem_be` = 4'b1100, and at offset 2 drives 4'b0011. In both cases `mem_wdata` = {st_data[15:0], st_data[15:0]}.
- R4: A byte store (size 2'b00) at offset k drives `mem_be` = 4'b1000 >> k. Exactly one bit is set, and `mem_wdata` holds st_data[7:0] in all four lanes.
- R5: A word access whose offset is not 0, or a halfword access at an odd offset, asserts `misalign`. In that cycle it drives `mem_req`, `mem_we` and `mem_be` to zero, and it produces no `ld_valid` in the next cycle.
- R6: An aligned load asserts `mem_req` with `mem_we` = 0 and `mem_be` = 0. `ld_valid` is high in the following cycle. For a word load, `ld_data` equals `mem_rdata` in that cycle.
- R7: A halfword load returns `mem_rdata[31:16]` at offset 0, or `mem_rdata[15:0]` at offset 2. The result is sign-extended to 32 bits.
- R8: A byte load at offset k returns `mem_rdata[31-8k -: 8]`, sign-extended to 32 bits.
- R9: During and right after reset `ld_valid` is 0, and `ld_valid` is never high unless a load was accepted in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| use_imm | input | 1 | Select immediate instead of index register |
| base | input | 32 | Base register value |
| index | input | 32 | Second register value |
| imm | input | IMM_W | Signed immediate offset |
| st_data | input | 32 | Store source register |
| mem_req | output | 1 | Access issued to memory |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Per-byte write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write data |
| misalign | output | 1 | Misaligned access flag |
| mem_rdata | input | 32 | Read word, valid the cycle after a load request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extracted, sign-extended load result |

## Verification
The bench builds the unit with its default 16-bit immediate. At that width, negative offsets that wrap the base address and positive offsets up to 32767 can both be reached. Random bases, sizes and offsets exercise every lane at every size for both addressing modes. These are mixed with directed misaligned accesses and with load words whose lane MSBs are set, to cover sign extension.

// File: rtl/lsu_align.sv
module lsu_align #(
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [1:0]       req_size,
  input  logic             use_imm,
  input  logic [31:0]      base,
  input  logic [31:0]      index,
  input  logic [IMM_W-1:0] imm,
  input  logic [31:0]      st_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  output logic             misalign,
  input  logic [31:0]      mem_rdata,
  output logic             ld_valid,
  output logic [31:0]      ld_data
);
  localparam int XW = 32;
  localparam int SX = XW - IMM_W;

  logic [XW-1:0] ea;
  logic [1:0]    off;
  logic          is_b, is_h, is_w, go;
  logic [3:0]    lanes;
  logic [1:0]    sz_q, off_q;

  assign ea   = base + (use_imm ? {{SX{imm[IMM_W-1]}}, imm} : index);
  assign off  = ea[1:0];
  assign is_b = (req_size == 2'b00);
  assign is_h = (req_size == 2'b01);
  assign is_w = req_size[1];

  assign misalign = req_valid & ((is_w & (off != 2'b00)) | (is_h & off[0]));
  assign go       = req_valid & ~misalign;
  assign mem_req  = go;
  assign mem_we   = go & req_store;
  assign mem_addr = {ea[XW-1:2], 2'b00};

  always_comb begin
    if (is_w)      lanes = 4'b1111;
    else if (is_h) lanes = off[1] ? 4'b0011 : 4'b1100;
    else           lanes = 4'b1000 >> off;
  end

  assign mem_be = mem_we ? lanes : 4'b0000;

  always_comb begin
    if (is_b)      mem_wdata = {4{st_data[7:0]}};
    else if (is_h) mem_wdata = {2{st_data[15:0]}};
    else           mem_wdata = st_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      sz_q     <= 2'b00;
      off_q    <= 2'b00;
    end else begin
      ld_valid <= go & ~req_store;
      if (go & ~req_store) begin
        sz_q  <= req_size;
        off_q <= off;
      end
    end
  end

  logic [15:0] hsel;
  logic [7:0]  bsel;

  assign hsel = off_q[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  always_comb begin
    case (off_q)
      2'd0:    bsel = mem_rdata[31:24];
      2'd1:    bsel = mem_rdata[23:16];
      2'd2:    bsel = mem_rdata[15:8];
      default: bsel = mem_rdata[7:0];
    endcase
  end

  always_comb begin
    if (sz_q[1])            ld_data = mem_rdata;
    else if (sz_q == 2'b01) ld_data = {{16{hsel[15]}}, hsel};
    else                    ld_data = {{24{bsel[7]}}, bsel};
  end

  a_r5_no_write_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_be == 4'b0000 && !mem_we && !mem_req));
  a_r5_no_result_after_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> !ld_valid);
  a_r6_load_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && !misalign) |=> ld_valid);
  a_r6_load_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store) |-> (mem_be == 4'b0000 && !mem_we));
  a_r4_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == 2'b00) |-> $countones(mem_be) == 1);
  a_r2_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size[1]) |-> mem_be == 4'b1111);
  a_r9_valid_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_req && !mem_we));
endmodule

// File: tb/sim_lsu_align.sv
module sim_lsu_align;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, use_imm = 0;
  logic [1:0] req_size = 0;
  logic [31:0] base = 0, index = 0, st_data = 0, mem_rdata = 0;
  logic [15:0] imm = 0;
  logic mem_req, mem_we, misalign, ld_valid;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0] mem_be;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lsu_align #(.IMM_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .use_imm(use_imm), .base(base), .index(index),
    .imm(imm), .st_data(st_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .misalign(misalign), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_data(ld_data));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_ea(logic [31:0] b, logic [31:0] x,
                                       logic [15:0] i, logic ui);
    return ui ? b + {{16{i[15]}}, i} : b + x;
  endfunction

  function automatic logic f_bad(logic [1:0] s, logic [1:0] o);
    if (s[1]) return o != 0;
    if (s == 2'b01) return o[0];
    return 1'b0;
  endfunction

  function automatic logic [3:0] f_be(logic [1:0] s, logic [1:0] o);
    if (s[1]) return 4'b1111;
    if (s == 2'b01) return (o == 2) ? 4'b0011 : 4'b1100;
    case (o)
      2'd0: return 4'b1000;
      2'd1: return 4'b0100;
      2'd2: return 4'b0010;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [31:0] f_wd(logic [1:0] s, logic [31:0] d);
    if (s[1]) return d;
    if (s == 2'b01) return {d[15:0], d[15:0]};
    return {d[7:0], d[7:0], d[7:0], d[7:0]};
  endfunction

  function automatic logic [31:0] f_ld(logic [1:0] s, logic [1:0] o, logic [31:0] w);
    logic [7:0] b8;
    logic [15:0] h16;
    if (s[1]) return w;
    if (s == 2'b01) begin
      h16 = (o == 2) ? w[15:0] : w[31:16];
      return {{16{h16[15]}}, h16};
    end
    b8 = w >> (8 * (3 - o));
    return {{24{b8[7]}}, b8};
  endfunction

  task automatic access(logic st, logic [1:0] s, logic ui, logic [31:0] b,
                        logic [31:0] x, logic [15:0] i, logic [31:0] d,
                        logic [31:0] rword);
    logic [31:0] ea;
    logic bad;
    string tag;
    ea  = f_ea(b, x, i, ui);
    bad = f_bad(s, ea[1:0]);
    tag = s[1] ? "R2" : (s == 2'b01 ? "R3" : "R4");
    @(negedge clk);
    req_valid = 1; req_store = st; req_size = s; use_imm = ui;
    base = b; index = x; imm = i; st_data = d;
    #1;
    chk("R5", {31'b0, misalign}, {31'b0, bad});
    if (bad) begin
      chk("R5", {28'b0, mem_be, mem_req, mem_we}, 32'h0);
    end else begin
      chk("R1", mem_addr, {ea[31:2], 2'b00});
      chk(st ? "R1" : "R6", {31'b0, mem_req}, 32'h1);
      if (st) begin
        chk(tag, {28'b0, mem_be}, {28'b0, f_be(s, ea[1:0])});
        chk(tag, mem_wdata, f_wd(s, d));
      end else begin
        chk("R6", {30'b0, mem_be == 0, mem_we}, 32'h2);
      end
    end
    @(negedge clk);
    req_valid = 0; mem_rdata = rword;
    #1;
    chk(bad ? "R5" : "R9", {31'b0, ld_valid}, {31'b0, !st && !bad});
    if (!st && !bad)
      chk(s[1] ? "R6" : (s == 2'b01 ? "R7" : "R8"), ld_data, f_ld(s, ea[1:0], rword));
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    #1 chk("R9", {31'b0, ld_valid}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    #1 chk("R9", {31'b0, ld_valid}, 32'h0);
    access(1, 2'b10, 0, 32'h1000, 32'h0008, 0, 32'hDEADBEEF, 0);
    access(1, 2'b01, 1, 32'h1000, 0, 16'h0002, 32'h0000ABCD, 0);
    access(1, 2'b01, 1, 32'h1004, 0, 16'hFFFC, 32'h00001234, 0);
    for (int k = 0; k < 4; k++)
      access(1, 2'b00, 0, 32'h2000, k, 0, 32'h000000A5, 0);
    access(1, 2'b10, 0, 32'h3000, 32'h1, 0, 32'h1, 0);
    access(0, 2'b11, 1, 32'h3000, 0, 16'h0002, 0, 32'h11223344);
    access(1, 2'b01, 0, 32'h3001, 0, 0, 32'h55, 0);
    access(0, 2'b01, 1, 32'h3000, 0, 16'hFFFF, 0, 32'h80008000);
    access(0, 2'b10, 0, 32'h4000, 32'h4, 0, 0, 32'hCAFEF00D);
    access(0, 2'b01, 0, 32'h4000, 32'h0, 0, 0, 32'h80017FFF);
    access(0, 2'b01, 0, 32'h4000, 32'h2, 0, 0, 32'h80017FFF);
    for (int k = 0; k < 4; k++)
      access(0, 2'b00, 1, 32'h5000, 0, k[15:0], 0, 32'h80FF7F01);
    access(0, 2'b00, 1, 32'h0000_0002, 0, 16'hFFFD, 0, 32'h000000F0);
    for (int n = 0; n < 400; n++) begin
      logic [1:0] s;
      logic [31:0] b, x;
      s = 2'($urandom);
      b = $urandom;
      x = $urandom;
      if ($urandom % 3 != 0) begin
        b[1:0] = 0;
        x[1:0] = (s == 2'b00) ? x[1:0] : (s == 2'b01 ? {x[1], 1'b0} : 2'b00);
      end
      access(1'($urandom), s, 1'($urandom), b, x, 16'($urandom), $urandom, $urandom);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule